// File: doc/BRIEF.md
# Decimating Pseudo-Random Bit and Word Source

This block holds a 16-bit maximal-length linear feedback shift register and gives its output in one of two forms. In bit mode the consumer takes a serial stream. Each enabled clock produces one fresh bit, which is the bit that leaves the low end of the register. In word mode the block hands out the whole register only after sixteen enabled shifts since the previous word, and flags each word with a one-cycle strobe. Because of this, two consecutive words never share a state bit. The block never exposes the register once per shift as a word. Such words are only shifted copies of each other: each one is the last one halved, possibly plus 32768.

The consumer paces the source through `advance_en`. The source has no ready input and no back-pressure, because a word that is not taken is simply overwritten 16 shifts later. A seed port reloads the register at any time. An all-zero seed would lock the register, so the block swaps it for a fixed non-zero value. Loading a seed or switching mode restarts the count toward the next word.

Top module: `lfsr_rng_decim`

## Requirements
- R1: Each enabled step shifts the register right by one position. The new bit 15 is the XOR of bits 0, 2, 3 and 5, which are polynomial taps 16, 14, 13 and 11. The register never holds zero.
- R2: `rand_bit` is registered. After each enabled step it shows the bit that left bit 0 during that step, so one new bit appears per enabled clock in either mode.
- R3: When `out_mode` is 1 (word mode), `word_valid` is high for exactly the one cycle that follows every 16th enabled step. In that cycle `rand_word` equals the register value after that step, and `rand_word` keeps that value until the next word.
- R4: When `out_mode` is 0 (bit mode), `word_valid` stays low and `rand_word` keeps its value.
- R5: `seed_load` has priority over stepping. It loads `seed_value` into the register, or 16'hACE1 when `seed_value` is zero, and it restarts the 16-step count. No step occurs in that cycle.
- R6: In a cycle where `out_mode` differs from its value in the previous cycle, no step occurs and the 16-step count restarts.
- R7: While `advance_en` is low, the register, the step count and `rand_bit` hold their values, and `word_valid` is low.
- R8: The synchronous reset `rst` sets the register to 16'hACE1, clears the count, clears `rand_bit`, `rand_word` and `word_valid`, and takes bit mode as the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_value` into the register this cycle |
| seed_value | input | 16 | Seed; zero is replaced by 16'hACE1 |
| advance_en | input | 1 | Allow one step this cycle |
| out_mode | input | 1 | 0 selects bit mode, 1 selects word mode |
| rand_bit | output | 1 | Serial random bit |
| rand_word | output | 16 | Last issued random word |
| word_valid | output | 1 | One-cycle strobe marking a new `rand_word` |

## Verification
Every result is due one clock after the edge that causes it. `rand_bit` changes one cycle after an enabled step. `word_valid` and `rand_word` change one cycle after the 16th step. A seed load or a mode change costs one cycle in which nothing shifts. The bench drives its inputs just after a rising edge and samples the outputs just after the next edge. Its reference register takes exactly one step per sampled enabled cycle and none in load or mode-change cycles, so a word that arrives early or late fails the check for the cycle in which it appears.

// File: rtl/lfsr_rng_pkg.sv
package lfsr_rng_pkg;
  localparam int unsigned RNG_W = 16;
  // taps 16,14,13,11 as register bit indices 0,2,3,5 for a right-shifting register
  localparam logic [RNG_W-1:0] RNG_TAPS = 16'h002D;
  localparam logic [RNG_W-1:0] RNG_SAFE_SEED = 16'hACE1;

  typedef enum logic {
    MODE_BIT  = 1'b0,
    MODE_WORD = 1'b1
  } rng_mode_e;
endpackage

// File: rtl/lfsr_rng_core.sv
module lfsr_rng_core
  import lfsr_rng_pkg::*;
#(
  parameter int unsigned W = RNG_W,
  parameter logic [W-1:0] TAP_MASK = RNG_TAPS,
  parameter logic [W-1:0] SAFE_SEED = RNG_SAFE_SEED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state,
  output logic [W-1:0] state_next,
  output logic         out_bit
);
  logic [W-1:0] seed_clean;
  logic         feedback;

  // an all-zero state never leaves zero, so it is swapped out at load
  assign seed_clean = (seed == '0) ? SAFE_SEED : seed;
  assign feedback   = ^(state & TAP_MASK);
  assign state_next = {feedback, state[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SAFE_SEED;
      out_bit <= 1'b0;
    end else if (load) begin
      state   <= seed_clean;
    end else if (step) begin
      state   <= state_next;
      out_bit <= state[0];
    end
  end

  p_shift_right_r1: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (state[W-2:0] == $past(state[W-1:1])));

  p_never_zero_r1: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  p_zero_seed_r5: assert property (@(posedge clk) disable iff (rst)
    (load && seed == '0) |=> (state == SAFE_SEED));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> ($stable(state) && $stable(out_bit)));
endmodule

// File: rtl/lfsr_rng_pacer.sv
module lfsr_rng_pacer
  import lfsr_rng_pkg::*;
#(
  parameter int unsigned SHIFTS  = RNG_W,
  parameter int unsigned COUNT_W = $clog2(SHIFTS)
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic load,
  input  logic mode,
  output logic step,
  output logic wrap
);
  localparam logic [COUNT_W-1:0] LAST = COUNT_W'(SHIFTS - 1);

  logic [COUNT_W-1:0] cnt;
  logic               mode_q;
  logic               mode_chg;

  assign mode_chg = (mode != mode_q);
  assign step     = enable && !load && !mode_chg;
  assign wrap     = step && (mode == MODE_WORD) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_BIT;
      cnt    <= '0;
    end else begin
      mode_q <= mode;
      if (load || mode_chg) begin
        cnt <= '0;
      end else if (step) begin
        if (mode == MODE_WORD) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        else                   cnt <= '0;
      end
    end
  end

  p_count_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (!enable && !load && !mode_chg) |=> $stable(cnt));

  p_mode_restart_r6: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (cnt == '0));

  p_load_restart_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0));

  p_bit_mode_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_BIT) |-> (cnt == '0));
endmodule

// File: rtl/lfsr_rng_word_stage.sv
module lfsr_rng_word_stage
  import lfsr_rng_pkg::*;
#(
  parameter int unsigned W = RNG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wrap,
  input  logic [W-1:0] fresh,
  output logic [W-1:0] word,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= wrap;
      if (wrap) word <= fresh;
    end
  end

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(word));
endmodule

// File: rtl/lfsr_rng_decim.sv
module lfsr_rng_decim
  import lfsr_rng_pkg::*;
#(
  parameter int unsigned W = RNG_W,
  parameter logic [W-1:0] TAP_MASK = RNG_TAPS,
  parameter logic [W-1:0] SAFE_SEED = RNG_SAFE_SEED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_load,
  input  logic [W-1:0] seed_value,
  input  logic         advance_en,
  input  logic         out_mode,
  output logic         rand_bit,
  output logic [W-1:0] rand_word,
  output logic         word_valid
);
  localparam int unsigned SHIFTS  = W;
  localparam int unsigned COUNT_W = $clog2(SHIFTS);

  logic         step;
  logic         wrap;
  logic [W-1:0] state;
  logic [W-1:0] state_next;

  lfsr_rng_pacer #(.SHIFTS(SHIFTS), .COUNT_W(COUNT_W)) u_pacer (
    .clk(clk), .rst(rst), .enable(advance_en), .load(seed_load),
    .mode(out_mode), .step(step), .wrap(wrap)
  );

  lfsr_rng_core #(.W(W), .TAP_MASK(TAP_MASK), .SAFE_SEED(SAFE_SEED)) u_core (
    .clk(clk), .rst(rst), .load(seed_load), .seed(seed_value), .step(step),
    .state(state), .state_next(state_next), .out_bit(rand_bit)
  );

  lfsr_rng_word_stage #(.W(W)) u_word (
    .clk(clk), .rst(rst), .wrap(wrap), .fresh(state_next),
    .word(rand_word), .valid(word_valid)
  );

  p_no_word_in_bit_mode_r4: assert property (@(posedge clk) disable iff (rst)
    (out_mode == MODE_BIT) |=> !word_valid);

  p_idle_no_word_r7: assert property (@(posedge clk) disable iff (rst)
    !advance_en |=> !word_valid);

  p_word_is_state_r3: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (rand_word == state));
endmodule

// File: tb/lfsr_rng_decim_tb.sv
module lfsr_rng_decim_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        seed_load;
  logic [15:0] seed_value;
  logic        advance_en;
  logic        out_mode;
  logic        rand_bit;
  logic [15:0] rand_word;
  logic        word_valid;

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_state;
  logic        ref_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_rng_decim u_dut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .advance_en(advance_en), .out_mode(out_mode), .rand_bit(rand_bit),
    .rand_word(rand_word), .word_valid(word_valid)
  );

  function automatic logic [15:0] ref_step(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_seed(input logic [15:0] s);
    seed_load = 1'b1; seed_value = s; advance_en = 1'b0;
    tick();
    seed_load = 1'b0;
    ref_state = (s == 16'h0) ? 16'hACE1 : s;
  endtask

  task automatic switch_mode(input logic m);
    out_mode = m; advance_en = 1'b1;
    tick();
    check("R6 no step on mode change", {15'h0, rand_bit}, {15'h0, ref_bit});
  endtask

  task automatic enabled_step(input string req, input bit expect_valid);
    advance_en = 1'b1;
    tick();
    ref_bit   = ref_state[0];
    ref_state = ref_step(ref_state);
    check(req, {15'h0, rand_bit}, {15'h0, ref_bit});
    check(req, {15'h0, word_valid}, {15'h0, expect_valid});
    if (expect_valid) check(req, rand_word, ref_state);
  endtask

  task automatic full_word(input string req);
    for (int i = 0; i < 16; i++) enabled_step(req, i == 15);
  endtask

  task automatic t_reset();
    rst = 1'b1; seed_load = 1'b0; seed_value = 16'h0; advance_en = 1'b0; out_mode = 1'b0;
    tick(); tick();
    rst = 1'b0;
    ref_state = 16'hACE1; ref_bit = 1'b0;
    tick();
    check("R8 rand_bit", {15'h0, rand_bit}, 16'h0);
    check("R8 rand_word", rand_word, 16'h0);
    check("R8 word_valid", {15'h0, word_valid}, 16'h0);
    for (int i = 0; i < 20; i++) enabled_step("R8 R1 R2 bit stream from reset seed", 1'b0);
  endtask

  task automatic t_bit_mode();
    logic [15:0] held;
    load_seed(16'h1234);
    held = rand_word;
    for (int i = 0; i < 40; i++) begin
      enabled_step("R2 R4 bit mode", 1'b0);
      check("R4 word held", rand_word, held);
    end
  endtask

  task automatic t_word_mode();
    switch_mode(1'b1);
    load_seed(16'h8001);
    full_word("R3 R1 first word");
    full_word("R3 second word");
    full_word("R3 third word");
  endtask

  task automatic t_zero_seed();
    load_seed(16'h0000);
    full_word("R5 zero seed replaced");
  endtask

  task automatic t_freeze();
    load_seed(16'h5A5A);
    for (int i = 0; i < 8; i++) enabled_step("R7 before pause", 1'b0);
    advance_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R7 bit frozen", {15'h0, rand_bit}, {15'h0, ref_bit});
      check("R7 no word", {15'h0, word_valid}, 16'h0);
    end
    for (int i = 0; i < 8; i++) enabled_step("R7 after pause", i == 7);
  endtask

  task automatic t_mode_restart();
    load_seed(16'h0F0F);
    for (int i = 0; i < 5; i++) enabled_step("R6 before switch", 1'b0);
    switch_mode(1'b0);
    switch_mode(1'b1);
    full_word("R6 count restarted");
  endtask

  task automatic t_load_restart();
    for (int i = 0; i < 7; i++) enabled_step("R5 before reload", 1'b0);
    seed_load = 1'b1; seed_value = 16'hBEEF; advance_en = 1'b1;
    tick();
    seed_load = 1'b0;
    ref_state = 16'hBEEF;
    check("R5 load beats step", {15'h0, rand_bit}, {15'h0, ref_bit});
    full_word("R5 count restarted by load");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_bit_mode();
    t_word_mode();
    t_zero_seed();
    t_freeze();
    t_mode_restart();
    t_load_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule